// File: doc/BRIEF.md
# Halfword-Assembled Word Buffer with Rewindable Readout

This block keeps a fixed-depth table of signed 20-bit words in on-chip RAM. A refresh pulls the table in from an external memory port that is 16 bits wide and has unpredictable latency. Each table entry takes two halfword reads. The read at the 4-byte-aligned address gives the low 16 bits. The read two bytes above it gives the top four bits. When every entry has been written, a done flag rises.

A consumer reads the table one entry at a time with a request/acknowledge handshake. The block raises a last flag on the final entry. After the last entry the read pointer wraps to entry 0, so the table can be streamed as often as needed. A rewind input sends the pointer back to entry 0 at any time. Consumer requests made while a refresh is under way wait until the refresh is complete.

The refresh engine has six states. `F_IDLE` waits for the start strobe. `F_LO` fetches the low half. `F_MID` is a gap cycle with the request low. `F_HI` fetches the high half and writes the entry. `F_STEP` is a gap cycle before the next entry. `F_DONE` holds the done flag until the start strobe is dropped. Its transitions are:

- IDLE to LO on start.
- LO to MID on valid.
- MID to HI unconditionally.
- HI to STEP on valid for every entry but the last, and HI to DONE on valid for the last entry.
- STEP to LO unconditionally.
- DONE to IDLE when start goes low.

The readout engine has four states. `R_IDLE` waits for an accepted request. `R_FETCH` is the RAM read cycle. `R_OK` pulses the acknowledge. `R_WAIT` waits for the request to drop. Its transitions are:

- IDLE to FETCH when a request is accepted.
- FETCH to OK unconditionally.
- OK to WAIT unconditionally.
- WAIT to IDLE when the request is low.
- Rewind sends any state to IDLE.

Top module: `word_refill_buf`

## Requirements
- R1: A refresh starts when `fill_go` is high in the idle state. `fill_base` is captured at that point. Entry k is built from exactly two fetches, at byte addresses base+4k and base+4k+2, for a total of 2×DEPTH fetches per refresh.
- R2: Every fetch address is even, no lower than the base, and below base+4×DEPTH.
- R3: The fetch at base+4k supplies entry bits 15:0. Only bits 3:0 of the fetch at base+4k+2 are kept, as entry bits 19:16, and its bits 15:4 are discarded.
- R4: `mem_rd` stays high until `mem_ack` arrives, whatever the latency. After each `mem_ack`, `mem_rd` is low for at least one cycle. `mem_addr` does not change while `mem_rd` stays high.
- R5: `fill_done` rises after the last entry has been written. It stays high as long as `fill_go` is held, and it falls in the cycle after `fill_go` is removed.
- R6: A high `rd_req` produces a one-cycle `rd_ok` pulse with the entry on `rd_data`. `rd_data` stays unchanged until the next acknowledge.
- R7: `rd_last` is 1 exactly when the acknowledged entry is entry DEPTH-1. The request after that returns entry 0.
- R8: A one-cycle `rd_rewind` pulse returns the read pointer to entry 0 without changing the stored entries.
- R9: A request made while a refresh is running produces no `rd_ok` before `fill_done` is high. It is then served from the new contents.
- R10: After reset, `mem_rd`, `fill_done`, `rd_ok`, `rd_last` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_go | input | 1 | Refresh start strobe, held until done |
| fill_base | input | 32 | Byte start address of the source table |
| fill_done | output | 1 | Refresh complete |
| mem_rd | output | 1 | External read request |
| mem_addr | output | 32 | External halfword byte address |
| mem_ack | input | 1 | External read data valid |
| mem_data | input | 16 | External read data |
| rd_req | input | 1 | Consumer request for the next entry |
| rd_rewind | input | 1 | Return read pointer to entry 0 |
| rd_data | output | 20 | Entry being handed out |
| rd_ok | output | 1 | One-cycle acknowledge |
| rd_last | output | 1 | Acknowledged entry is the final one |

## Verification
The memory model in the bench varies its latency with the address and puts junk in the upper twelve bits of every high halfword. A design that counted cycles instead of waiting for valid would latch stale data. A design that kept too many high bits would show the junk in bits 19:16.

The bench makes two full passes per refresh and checks that only the final entry carries the last flag. A pointer that did not wrap, or that flagged the wrong entry, would fail there. A rewind in mid-pass must bring back entry 0 with its old value. A rewind that touched the RAM, or did not reset the pointer, would return the wrong entry.

A request raised together with the start strobe must stay unanswered until the refresh is done. A design that served it early would hand out a stale entry.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

    typedef enum logic [2:0] {
        F_IDLE,
        F_LO,
        F_MID,
        F_HI,
        F_STEP,
        F_DONE
    } fill_st_t;

    typedef enum logic [1:0] {
        R_IDLE,
        R_FETCH,
        R_OK,
        R_WAIT
    } read_st_t;

endpackage

// File: rtl/wrb_fill_fsm.sv
module wrb_fill_fsm
    import wrb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 20,
    parameter int HW_W   = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int HI_W  = DATA_W - HW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] base,
    output logic              done,
    output logic              busy,
    output logic              hold,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [HW_W-1:0]   mem_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_word
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

    fill_st_t         st, nxt;
    logic [IDX_W-1:0] idx;
    logic [HW_W-1:0]  lo_q;
    logic             at_last;

    assign at_last = (idx == LAST_IDX);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= F_IDLE;
        else        st <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            F_IDLE: if (go)      nxt = F_LO;
            F_LO:   if (mem_ack) nxt = F_MID;
            F_MID:               nxt = F_HI;
            F_HI:   if (mem_ack) nxt = at_last ? F_DONE : F_STEP;
            F_STEP:              nxt = F_LO;
            F_DONE: if (!go)     nxt = F_IDLE;
            default:             nxt = F_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_rd  = (st == F_LO) || (st == F_HI);
        done    = (st == F_DONE);
        busy    = (st != F_IDLE) && (st != F_DONE);
        hold    = busy || ((st == F_IDLE) && go);
        wr_en   = (st == F_HI) && mem_ack;
        wr_idx  = idx;
        wr_word = {mem_data[HI_W-1:0], lo_q};
    end

    // address, index and low-half datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            idx      <= '0;
            lo_q     <= '0;
        end else begin
            unique case (st)
                F_IDLE: if (go) begin
                    mem_addr <= base;
                    idx      <= '0;
                end
                F_LO: if (mem_ack) begin
                    lo_q     <= mem_data;
                    mem_addr <= mem_addr + HALF_STEP;
                end
                F_HI: if (mem_ack && !at_last) begin
                    mem_addr <= mem_addr + HALF_STEP;
                    idx      <= idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wrb_store.sv
module wrb_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[widx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re) rdata <= cells[ridx];
    end

endmodule

// File: rtl/wrb_read_fsm.sv
module wrb_read_fsm
    import wrb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              req,
    input  logic              rewind,
    output logic              ren,
    output logic [IDX_W-1:0]  raddr,
    input  logic [DATA_W-1:0] ram_q,
    output logic [DATA_W-1:0] out_data,
    output logic              out_ok,
    output logic              out_last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    read_st_t         st, nxt;
    logic [IDX_W-1:0] ptr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= R_IDLE;
        else        st <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = st;
        if (rewind) begin
            nxt = R_IDLE;
        end else begin
            unique case (st)
                R_IDLE:  if (req && !hold) nxt = R_FETCH;
                R_FETCH:                   nxt = R_OK;
                R_OK:                      nxt = R_WAIT;
                R_WAIT:  if (!req)         nxt = R_IDLE;
                default:                   nxt = R_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ren    = (st == R_IDLE) && req && !hold && !rewind;
        raddr  = ptr;
        out_ok = (st == R_OK);
    end

    // pointer and output word registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            out_data <= '0;
            out_last <= 1'b0;
        end else begin
            if (rewind) begin
                ptr <= '0;
            end else if (st == R_OK) begin
                ptr <= (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
            end
            if (st == R_FETCH && !rewind) begin
                out_data <= ram_q;
                out_last <= (ptr == LAST_IDX);
            end
        end
    end

endmodule

// File: rtl/word_refill_buf.sv
module word_refill_buf
    import wrb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 20,
    parameter int HW_W   = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_go,
    input  logic [ADDR_W-1:0] fill_base,
    output logic              fill_done,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [HW_W-1:0]   mem_data,
    input  logic              rd_req,
    input  logic              rd_rewind,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ok,
    output logic              rd_last
);

    localparam int IDX_W = $clog2(DEPTH);

    logic              fill_busy;
    logic              fill_hold;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_word;
    logic              ren;
    logic [IDX_W-1:0]  raddr;
    logic [DATA_W-1:0] ram_q;

    wrb_fill_fsm #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .HW_W(HW_W), .ADDR_W(ADDR_W)
    ) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (fill_go),
        .base     (fill_base),
        .done     (fill_done),
        .busy     (fill_busy),
        .hold     (fill_hold),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr),
        .mem_ack  (mem_ack),
        .mem_data (mem_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_word  (wr_word)
    );

    wrb_store #(
        .DEPTH(DEPTH), .DATA_W(DATA_W)
    ) u_store (
        .clk   (clk),
        .we    (wr_en),
        .widx  (wr_idx),
        .wdata (wr_word),
        .re    (ren),
        .ridx  (raddr),
        .rdata (ram_q)
    );

    wrb_read_fsm #(
        .DEPTH(DEPTH), .DATA_W(DATA_W)
    ) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (fill_hold),
        .req      (rd_req),
        .rewind   (rd_rewind),
        .ren      (ren),
        .raddr    (raddr),
        .ram_q    (ram_q),
        .out_data (rd_data),
        .out_ok   (rd_ok),
        .out_last (rd_last)
    );

endmodule

// File: rtl/word_refill_buf_chk.sv
module word_refill_buf_chk #(
    parameter int DATA_W = 20,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fill_go,
    input logic              fill_done,
    input logic              fill_busy,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_ok
);

    // R4
    rd_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && !mem_ack |=> mem_rd);

    // R4
    rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && mem_ack |=> !mem_rd);

    // R4
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd || $stable(mem_addr)));

    // R2
    addr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr[0] == 1'b0));

    // R5
    done_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done && fill_go |=> fill_done);

    // R6
    ok_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |=> !rd_ok);

    // R6
    data_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |-> $stable(rd_data));

    // R9
    no_ok_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_busy && $past(fill_busy) |-> !rd_ok);

endmodule

bind word_refill_buf word_refill_buf_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/word_refill_buf_tb.sv
module word_refill_buf_tb;

    localparam int DEPTH  = 16;
    localparam int DATA_W = 20;
    localparam int NVEC   = 4;

    // {base address, pattern seed}
    localparam logic [63:0] VECS [NVEC] = '{
        {32'h0001_2340, 32'd3},
        {32'h0000_0000, 32'd11},
        {32'h00AB_CDE0, 32'd57},
        {32'hFFFF_FF00, 32'd200}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_go = 1'b0;
    logic [31:0] fill_base = '0;
    logic        fill_done;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_data = '0;
    logic        rd_req = 1'b0;
    logic        rd_rewind = 1'b0;
    logic [19:0] rd_data;
    logic        rd_ok;
    logic        rd_last;

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] lo_m [DEPTH];
    logic [15:0] hi_m [DEPTH];
    logic [31:0] base_cur = '0;
    int          fetch_cnt = 0;
    int          lat_cnt = 0;

    always #2.5 clk = ~clk;

    word_refill_buf u_dut (
        .clk(clk), .rst_n(rst_n), .fill_go(fill_go), .fill_base(fill_base),
        .fill_done(fill_done), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_data(mem_data), .rd_req(rd_req),
        .rd_rewind(rd_rewind), .rd_data(rd_data), .rd_ok(rd_ok),
        .rd_last(rd_last)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_word(input int k);
        return {hi_m[k][3:0], lo_m[k]};
    endfunction

    // External memory model: latency depends on address, junk in hi bits 15:4
    always @(negedge clk) begin
        logic [31:0] off;
        int k;
        if (!mem_rd) begin
            mem_ack = 1'b0;
            lat_cnt = 0;
        end else if (!mem_ack) begin
            if (lat_cnt == 1 + int'((mem_addr >> 1) & 32'd3)) begin
                off = mem_addr - base_cur;
                fetch_cnt++;
                // R2: bounds and alignment of each fetch
                check(mem_addr[0] == 1'b0 && off < 32'(4 * DEPTH) &&
                      mem_addr >= base_cur, "R2 fetch addr", mem_addr, base_cur);
                k = int'(off >> 2) % DEPTH;
                mem_data = off[1] ? hi_m[k] : lo_m[k];
                mem_ack = 1'b1;
            end
            lat_cnt++;
        end
    end

    task automatic load_pattern(input int seed);
        for (int k = 0; k < DEPTH; k++) begin
            lo_m[k] = 16'(seed * 40503 + k * 7919);
            hi_m[k] = 16'((seed * 1234 + k * 977) ^ 16'hA5F0);
        end
    endtask

    task automatic run_fill(input logic [31:0] base, input int seed, input bit with_req);
        int guard;
        load_pattern(seed);
        @(negedge clk);
        base_cur  = base;
        fill_base = base;
        fill_go   = 1'b1;
        fetch_cnt = 0;
        if (with_req) rd_req = 1'b1;
        guard = 0;
        @(negedge clk);
        while (!fill_done && guard < 5000) begin
            // R9: no acknowledge while refresh runs
            if (with_req) check(!rd_ok, "R9 ok during fill", 32'(rd_ok), 0);
            @(negedge clk);
            guard++;
        end
        check(fill_done, "R5 done raised", 32'(fill_done), 1);
        // R1: two fetches per entry
        check(fetch_cnt == 2 * DEPTH, "R1 fetch count", fetch_cnt, 2 * DEPTH);
        if (!with_req) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                check(fill_done, "R5 done held", 32'(fill_done), 1);
            end
            fill_go = 1'b0;
            @(negedge clk);
            check(!fill_done, "R5 done drops", 32'(fill_done), 0);
        end
    endtask

    task automatic read_one(output logic [19:0] d, output logic l);
        int guard = 0;
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        while (!rd_ok && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        check(rd_ok, "R6 ok seen", 32'(rd_ok), 1);
        d = rd_data;
        l = rd_last;
        rd_req = 1'b0;
        @(negedge clk);
        // R6: single-cycle pulse
        check(!rd_ok, "R6 ok one cycle", 32'(rd_ok), 0);
    endtask

    task automatic read_pass(input string tag);
        logic [19:0] d;
        logic        l;
        for (int k = 0; k < DEPTH; k++) begin
            read_one(d, l);
            // R3 entry assembly; R7 last flag
            check(d == exp_word(k), {tag, " R3 word"}, 32'(d), 32'(exp_word(k)));
            check(l == (k == DEPTH - 1), {tag, " R7 last"}, 32'(l), 32'(k == DEPTH - 1));
        end
    endtask

    initial begin
        logic [19:0] d;
        logic        l;
        int          guard;

        repeat (3) @(negedge clk);
        // R10: reset values
        check(!mem_rd && !fill_done && !rd_ok && !rd_last && rd_data == '0,
              "R10 reset state", {mem_rd, fill_done, rd_ok, rd_last, 8'h0, rd_data[19:0]}, 0);
        rst_n = 1'b1;

        // vector table: refresh, then two passes (R7 wrap)
        for (int v = 0; v < NVEC; v++) begin
            run_fill(VECS[v][63:32], int'(VECS[v][31:0]), 1'b0);
            read_pass("pass1");
            read_pass("pass2 R7");
        end

        // R6: output held after acknowledge
        read_one(d, l);
        repeat (4) @(negedge clk);
        check(rd_data == d && !rd_ok, "R6 data held", 32'(rd_data), 32'(d));

        // R8: rewind in mid pass
        for (int k = 1; k < 5; k++) read_one(d, l);
        @(negedge clk);
        rd_rewind = 1'b1;
        @(negedge clk);
        rd_rewind = 1'b0;
        read_pass("R8 after rewind");

        // R9: request raised together with start is held until done
        run_fill(32'h0004_0000, 91, 1'b1);
        guard = 0;
        while (!rd_ok && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        check(rd_ok && rd_data == {hi_m[0][3:0], lo_m[0]}, "R9 first word after fill",
              32'(rd_data), 32'({hi_m[0][3:0], lo_m[0]}));
        rd_req  = 1'b0;
        fill_go = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!fill_done, "R5 done drops", 32'(fill_done), 0);
        for (int k = 1; k < DEPTH; k++) begin
            read_one(d, l);
            check(d == exp_word(k), "R9 R1 word", 32'(d), 32'(exp_word(k)));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule